// File: doc/BRIEF.md
# Armed Compare Channel

This block is a single one-shot alarm channel that watches a free-running time value counted in 8 us ticks. Software loads a target time into the channel, and the load itself arms it. While the channel is armed it compares the live tick count with the target. Once the count has reached the target, or has passed it by less than one second, the channel emits a single event pulse, sets its raw interrupt flag and disarms itself.

A target can be loaded at 250 ns, 1 us or 8 us resolution. Finer values are scaled down to 8 us units before they are stored, and the stored value can be read back at each of the three resolutions. A disarm strobe drops the channel back to idle without an event. If a disarm lands in the same cycle as a match, the match still delivers its event. The raw flag has write-1 set and clear strobes, a mask with its own set and clear strobes, and a masked status output.

The time counter and the bus decoding that produces the strobes are outside this block. Every strobe is a single-cycle pulse.

Top module: `cmp_chan_top`

## Requirements
- R1: A pulse on any of the three load strobes arms the channel, and `armed_o` reads 1 from the next clock edge. If more than one strobe is high, the 8 us load wins, then the 1 us load.
- R2: The stored target `cmp_coarse_o` takes the data unchanged for an 8 us load, the data shifted right by 3 for a 1 us load, and the data shifted right by 5 for a 250 ns load. `cmp_mid_o` reads the stored target shifted left by 3 with zeros below it. `cmp_fine_o` reads it shifted left by 5 with zeros below it. Both readbacks are truncated to 32 bits.
- R3: An armed channel matches at a clock edge when (time − target) mod 2^32 < 125000. `event_o` is then high for exactly the following cycle.
- R4: A match disarms the channel, so one arming produces exactly one event even if time stays inside the window.
- R5: A disarm pulse with no match in the same cycle clears `armed_o` at the next edge, and no event follows.
- R6: A disarm pulse in the same cycle as a match still produces the event and leaves the channel unarmed.
- R7: A pulse on the arm-set strobe changes neither `armed_o` nor the event output, whether the channel is armed or idle.
- R8: The raw flag `raw_o` is set by a match or by an interrupt-set pulse. It is cleared by an interrupt-clear pulse or by any load strobe. A setting cause wins over a clearing cause in the same cycle.
- R9: The mask is set by a mask-set pulse and cleared by a mask-clear pulse, with set winning when both are high. `masked_o` equals `raw_o` AND `mask_o`.
- R10: After reset the channel is unarmed, and the target, the flag, the mask, the masked status and the event output are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | 32 | Live time in 8 us ticks |
| ld_fine_i | input | 1 | Load target given in 250 ns units |
| ld_mid_i | input | 1 | Load target given in 1 us units |
| ld_coarse_i | input | 1 | Load target given in 8 us units |
| ld_data_i | input | 32 | Target value for the load strobes |
| disarm_i | input | 1 | Disarm strobe |
| armset_i | input | 1 | Arm-set strobe, no effect on this channel |
| irq_set_i | input | 1 | Set the raw flag |
| irq_clr_i | input | 1 | Clear the raw flag |
| mask_set_i | input | 1 | Set the mask |
| mask_clr_i | input | 1 | Clear the mask |
| armed_o | output | 1 | Channel armed |
| event_o | output | 1 | One-cycle event pulse |
| cmp_coarse_o | output | 32 | Stored target, 8 us units |
| cmp_mid_o | output | 32 | Stored target viewed at 1 us resolution |
| cmp_fine_o | output | 32 | Stored target viewed at 250 ns resolution |
| raw_o | output | 1 | Raw interrupt flag |
| mask_o | output | 1 | Interrupt mask |
| masked_o | output | 1 | Masked interrupt status |

## Verification
The assertions check the cycle-to-cycle rules on every cycle:
- a load arms the channel;
- a match or a plain disarm leaves it idle;
- a disarm racing a match still yields the event;
- the arm-set strobe leaves the state unchanged;
- the flag and mask strobes take effect one edge later;
- every event comes from an armed in-window match.

Only the bench scenarios can show the following:
- the exact window edges, at offsets 0, 124999 and 125000, one tick early, and wrap-around of the target and of time;
- the scaling and readback arithmetic for each load resolution;
- that a channel left inside the window fires exactly once.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int TW      = 32;
  localparam int MID_SH  = 3;
  localparam int FINE_SH = 5;
  localparam int PAST_WIN = 125000;

  typedef enum logic [1:0] {
    LD_NONE   = 2'd0,
    LD_FINE   = 2'd1,
    LD_MID    = 2'd2,
    LD_COARSE = 2'd3
  } ld_sel_e;
endpackage

// File: rtl/cmp_store.sv
module cmp_store
  import cmp_pkg::*;
#(
  parameter int W = TW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_fine_i,
  input  logic         ld_mid_i,
  input  logic         ld_coarse_i,
  input  logic [W-1:0] ld_data_i,
  output logic         ld_any_o,
  output logic [W-1:0] cmp_o,
  output logic [W-1:0] cmp_mid_o,
  output logic [W-1:0] cmp_fine_o
);
  ld_sel_e      sel;
  logic [W-1:0] scaled;
  logic [W-1:0] cmp_q;

  always_comb begin
    if (ld_coarse_i)    sel = LD_COARSE;
    else if (ld_mid_i)  sel = LD_MID;
    else if (ld_fine_i) sel = LD_FINE;
    else                sel = LD_NONE;
  end

  always_comb begin
    unique case (sel)
      LD_FINE: scaled = ld_data_i >> FINE_SH;
      LD_MID:  scaled = ld_data_i >> MID_SH;
      default: scaled = ld_data_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cmp_q <= '0;
    else if (sel != LD_NONE)  cmp_q <= scaled;
  end

  assign ld_any_o   = (sel != LD_NONE);
  assign cmp_o      = cmp_q;
  assign cmp_mid_o  = {cmp_q[W-1-MID_SH:0], {MID_SH{1'b0}}};
  assign cmp_fine_o = {cmp_q[W-1-FINE_SH:0], {FINE_SH{1'b0}}};

  // R2: a 1 us load stores the data divided by 8
  assert_mid_scale_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_mid_i && !ld_coarse_i) |=> cmp_q == ($past(ld_data_i) >> MID_SH));
  assert_coarse_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_coarse_i |=> cmp_q == $past(ld_data_i));
endmodule

// File: rtl/cmp_window.sv
module cmp_window
  import cmp_pkg::*;
#(
  parameter int W   = TW,
  parameter int WIN = PAST_WIN
) (
  input  logic [W-1:0] time_i,
  input  logic [W-1:0] cmp_i,
  output logic         in_win_o
);
  localparam logic [W-1:0] WIN_V = W'(WIN);
  logic [W-1:0] diff;

  // wrap-safe: how far time has run past the target
  assign diff     = time_i - cmp_i;
  assign in_win_o = diff < WIN_V;
endmodule

// File: rtl/cmp_arm.sv
module cmp_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_any_i,
  input  logic disarm_i,
  input  logic armset_i,
  input  logic in_win_i,
  output logic fire_o,
  output logic armed_o,
  output logic event_o
);
  logic armed_q, event_q, fire;

  assign fire = armed_q & in_win_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      event_q <= 1'b0;
    end else begin
      event_q <= fire;
      if (ld_any_i)               armed_q <= 1'b1;
      else if (fire || disarm_i)  armed_q <= 1'b0;
    end
  end

  assign fire_o  = fire;
  assign armed_o = armed_q;
  assign event_o = event_q;

  assert_arm_on_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_any_i |=> armed_q);
  assert_one_shot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !ld_any_i) |=> !armed_q);
  assert_disarm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disarm_i && !ld_any_i) |=> !armed_q);
  assert_disarm_race_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disarm_i && fire) |=> event_q);
  assert_armset_inert_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armset_i && !ld_any_i && !disarm_i && !fire) |=> $stable(armed_q));
endmodule

// File: rtl/cmp_irq.sv
module cmp_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic irq_set_i,
  input  logic irq_clr_i,
  input  logic ld_any_i,
  input  logic mask_set_i,
  input  logic mask_clr_i,
  output logic raw_o,
  output logic mask_o,
  output logic masked_o
);
  logic raw_q, mask_q, set_c, clr_c;

  assign set_c = fire_i | irq_set_i;
  assign clr_c = irq_clr_i | ld_any_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (set_c)       raw_q <= 1'b1;
      else if (clr_c)  raw_q <= 1'b0;
      if (mask_set_i)      mask_q <= 1'b1;
      else if (mask_clr_i) mask_q <= 1'b0;
    end
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_q & mask_q;

  assert_flag_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set_i |=> raw_q);
  assert_flag_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !irq_set_i && !fire_i) |=> !raw_q);
  assert_mask_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_set_i |=> mask_q);
  assert_mask_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_clr_i && !mask_set_i) |=> !mask_q);
endmodule

// File: rtl/cmp_chan_top.sv
module cmp_chan_top
  import cmp_pkg::*;
#(
  parameter int W   = TW,
  parameter int WIN = PAST_WIN
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] time_i,
  input  logic         ld_fine_i,
  input  logic         ld_mid_i,
  input  logic         ld_coarse_i,
  input  logic [W-1:0] ld_data_i,
  input  logic         disarm_i,
  input  logic         armset_i,
  input  logic         irq_set_i,
  input  logic         irq_clr_i,
  input  logic         mask_set_i,
  input  logic         mask_clr_i,
  output logic         armed_o,
  output logic         event_o,
  output logic [W-1:0] cmp_coarse_o,
  output logic [W-1:0] cmp_mid_o,
  output logic [W-1:0] cmp_fine_o,
  output logic         raw_o,
  output logic         mask_o,
  output logic         masked_o
);
  logic         ld_any, in_win, fire;
  logic [W-1:0] cmp_val;

  cmp_store #(.W(W)) u_store (
    .clk_i, .rst_ni, .ld_fine_i, .ld_mid_i, .ld_coarse_i, .ld_data_i,
    .ld_any_o(ld_any), .cmp_o(cmp_val), .cmp_mid_o, .cmp_fine_o
  );

  cmp_window #(.W(W), .WIN(WIN)) u_win (
    .time_i, .cmp_i(cmp_val), .in_win_o(in_win)
  );

  cmp_arm u_arm (
    .clk_i, .rst_ni, .ld_any_i(ld_any), .disarm_i, .armset_i,
    .in_win_i(in_win), .fire_o(fire), .armed_o, .event_o
  );

  cmp_irq u_irq (
    .clk_i, .rst_ni, .fire_i(fire), .irq_set_i, .irq_clr_i, .ld_any_i(ld_any),
    .mask_set_i, .mask_clr_i, .raw_o, .mask_o, .masked_o
  );

  assign cmp_coarse_o = cmp_val;

  assert_event_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> $past(in_win && armed_o));
  assert_event_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> raw_o);
endmodule

// File: tb/sim_cmp_chan_top.sv
module sim_cmp_chan_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] tm = '0, ld_data = '0;
  logic ld_fine = 0, ld_mid = 0, ld_coarse = 0, disarm = 0, armset = 0;
  logic irq_set = 0, irq_clr = 0, mask_set = 0, mask_clr = 0;
  logic armed, ev, raw, mask, masked;
  logic [31:0] c_coarse, c_mid, c_fine;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmp_chan_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .time_i(tm), .ld_fine_i(ld_fine),
    .ld_mid_i(ld_mid), .ld_coarse_i(ld_coarse), .ld_data_i(ld_data),
    .disarm_i(disarm), .armset_i(armset), .irq_set_i(irq_set),
    .irq_clr_i(irq_clr), .mask_set_i(mask_set), .mask_clr_i(mask_clr),
    .armed_o(armed), .event_o(ev), .cmp_coarse_o(c_coarse),
    .cmp_mid_o(c_mid), .cmp_fine_o(c_fine), .raw_o(raw), .mask_o(mask),
    .masked_o(masked)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_strobes();
    ld_fine = 0; ld_mid = 0; ld_coarse = 0; disarm = 0; armset = 0;
    irq_set = 0; irq_clr = 0; mask_set = 0; mask_clr = 0;
  endtask

  // load 8 us target while time sits 10 ticks before it
  task automatic arm_coarse(input logic [31:0] c);
    tm = c - 32'd10; ld_data = c; ld_coarse = 1;
    tick(); clear_strobes();
  endtask

  task automatic idle_out(input logic [31:0] c);
    tm = c - 32'd10; disarm = 1;
    tick(); clear_strobes();
    chk("R5 idle", {31'd0, armed}, 32'd0);
  endtask

  task automatic window_case(input logic [31:0] c, input logic [31:0] d);
    logic hit;
    hit = ((c + d) - c) < 32'd125000;
    arm_coarse(c);
    chk("R1 armed after load", {31'd0, armed}, 32'd1);
    tm = c + d;
    tick();
    chk("R3 event at window offset", {31'd0, ev}, {31'd0, hit});
    chk("R4 armed after match", {31'd0, armed}, {31'd0, !hit});
    tick();
    chk("R4 no second event", {31'd0, ev}, 32'd0);
    idle_out(c);
  endtask

  initial begin
    logic [31:0] cs [5];
    logic [31:0] ds [10];
    logic [31:0] xs [4];
    cs = '{32'd0, 32'd5, 32'd125000, 32'hFFFF_FFF0, 32'h8000_0000};
    ds = '{32'd0, 32'd1, 32'd124998, 32'd124999, 32'd125000, 32'd125001,
           32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h8000_0000, 32'd20};
    xs = '{32'hFFFF_FFFF, 32'h1234_5678, 32'd31, 32'hA5A5_0040};

    repeat (3) tick();
    // R10 reset state
    chk("R10 armed", {31'd0, armed}, 32'd0);
    chk("R10 event", {31'd0, ev}, 32'd0);
    chk("R10 target", c_coarse, 32'd0);
    chk("R10 flags", {29'd0, raw, mask, masked}, 32'd0);
    rst_n = 1; tick();

    // R3/R4 window sweep
    foreach (cs[i]) foreach (ds[j]) window_case(cs[i], ds[j]);

    // R2 scaling and readback for each load resolution
    foreach (xs[i]) begin
      tm = 32'd0 - 32'd500000; ld_data = xs[i]; ld_fine = 1; tick(); clear_strobes();
      chk("R2 fine load", c_coarse, xs[i] >> 5);
      chk("R2 mid view", c_mid, (xs[i] >> 5) << 3);
      chk("R2 fine view", c_fine, (xs[i] >> 5) << 5);
      chk("R1 fine load arms", {31'd0, armed}, 32'd1);
      idle_out(xs[i] >> 5);
      tm = 32'd0 - 32'd500000; ld_data = xs[i]; ld_mid = 1; tick(); clear_strobes();
      chk("R2 mid load", c_coarse, xs[i] >> 3);
      chk("R2 mid readback", c_mid, (xs[i] >> 3) << 3);
      chk("R1 mid load arms", {31'd0, armed}, 32'd1);
      tm = xs[i] >> 3; tick();
      chk("R3 mid load fires", {31'd0, ev}, 32'd1);
      idle_out(xs[i] >> 3);
    end
    // R1 priority: coarse beats mid
    tm = 32'd0; ld_data = 32'h0000_0800; ld_mid = 1; ld_coarse = 1; tick(); clear_strobes();
    chk("R1 coarse priority", c_coarse, 32'h0000_0800);
    idle_out(32'h800);

    // R5 disarm without match
    arm_coarse(32'd4000);
    tm = 32'd3000; disarm = 1; tick(); clear_strobes();
    chk("R5 disarm", {31'd0, armed}, 32'd0);
    chk("R5 no event on disarm", {31'd0, ev}, 32'd0);
    tm = 32'd4000; tick();
    chk("R5 no event later", {31'd0, ev}, 32'd0);
    tick();
    chk("R5 still no event", {31'd0, ev}, 32'd0);

    // R6 disarm racing match
    irq_clr = 1; tick(); clear_strobes();
    arm_coarse(32'd7000);
    tm = 32'd7000; disarm = 1; tick(); clear_strobes();
    chk("R6 event on race", {31'd0, ev}, 32'd1);
    chk("R6 unarmed", {31'd0, armed}, 32'd0);
    chk("R8 event sets flag", {31'd0, raw}, 32'd1);

    // R7 arm-set is inert
    tm = 32'd9000; armset = 1; tick(); clear_strobes();
    chk("R7 idle stays idle", {31'd0, armed}, 32'd0);
    chk("R7 no event", {31'd0, ev}, 32'd0);
    arm_coarse(32'd8000);
    armset = 1; tick(); clear_strobes();
    chk("R7 armed stays armed", {31'd0, armed}, 32'd1);

    // R8 flag rules (load cleared flag)
    chk("R8 load clears flag", {31'd0, raw}, 32'd0);
    irq_set = 1; tick(); clear_strobes();
    chk("R8 set", {31'd0, raw}, 32'd1);
    irq_clr = 1; tick(); clear_strobes();
    chk("R8 clear", {31'd0, raw}, 32'd0);
    irq_set = 1; irq_clr = 1; tick(); clear_strobes();
    chk("R8 set wins", {31'd0, raw}, 32'd1);
    ld_data = 32'd8000; ld_coarse = 1; tick(); clear_strobes();
    chk("R8 new load clears", {31'd0, raw}, 32'd0);

    // R9 mask
    irq_set = 1; tick(); clear_strobes();
    chk("R9 masked off", {31'd0, masked}, 32'd0);
    mask_set = 1; tick(); clear_strobes();
    chk("R9 mask set", {30'd0, mask, masked}, 32'd3);
    mask_clr = 1; tick(); clear_strobes();
    chk("R9 mask clear", {30'd0, mask, masked}, 32'd0);
    mask_set = 1; mask_clr = 1; tick(); clear_strobes();
    chk("R9 set wins", {31'd0, mask}, 32'd1);
    irq_clr = 1; tick(); clear_strobes();
    chk("R9 masked follows flag", {31'd0, masked}, 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule